// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives a serial interface clock from the system clock through two cascaded dividers. A linear stage divides by (pre + 1), where pre is a 4-bit code. A binary stage then divides by 2^post, where post is also a 4-bit code. One half-period of the serial clock therefore lasts H = (pre + 1) * 2^post system clock cycles. A shift engine beside it uses two one-cycle strobes, one for the leading edge and one for the trailing edge, to launch and capture data.

The codes can be loaded in two ways. A manual load takes both codes directly. An automatic load takes a source rate and a ceiling rate, and a built-in selector picks the codes so that source / ((pre + 1) * 2^post) never exceeds the ceiling. A load that no code pair can satisfy raises an error flag and leaves the previous setting in place. An accepted load is staged and reaches the live dividers only while the generator is idle. A setting therefore never changes in the middle of a clock phase.

Top module: `spi_clk_gen`

## Requirements
- R1: While rst is high at a clock edge, sclk takes the value of cpol. Both strobes are 0, both live codes are 0 and cfg_err is 0.
- R2: While the generator is idle (run low and the last phase finished), sclk equals cpol. A change of cpol while idle appears on sclk within two cycles.
- R3: While running, the lead strobe and the next trail strobe are H cycles apart, and the trail strobe and the next lead strobe are H cycles apart, where H = (pre_code + 1) * 2^post_code.
- R4: Each strobe is high for one cycle and the two are never high together. When lead_stb is high, sclk has just left the idle level. When trail_stb is high, sclk has just returned to the idle level.
- R5: On an automatic load with max_rate nonzero and src_rate <= max_rate, both codes become 0.
- R6: On an automatic load with src_rate > max_rate, let p = floor((src_rate - 1) / max_rate) and let n be the bit position of p's highest set bit counted from 1. If n <= 4, then pre = p and post = 0.
- R7: With p and n as in R6, if n > 4, then post = n - 4 and pre = p >> post.
- R8: An automatic load with max_rate = 0, or one where n - 4 >= 16, sets cfg_err and leaves the codes unchanged. Any accepted load clears cfg_err.
- R9: A manual load (cfg_auto = 0) takes pre_set and post_set as the new codes.
- R10: A load accepted while the generator runs does not change pre_code or post_code until the generator is idle. It then takes effect.
- R11: When run falls during a non-idle phase, the generator completes that phase. It ends with one trail strobe H cycles after the preceding lead strobe and starts no new lead edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (reference) clock |
| rst | input | 1 | Synchronous reset, active high |
| cpol | input | 1 | Idle level of sclk |
| run | input | 1 | Generate clock edges while high |
| cfg_load | input | 1 | One-cycle load of a new divider setting |
| cfg_auto | input | 1 | 1: choose codes from the rates, 0: use pre_set/post_set |
| src_rate | input | RW | Source rate for the automatic selector |
| max_rate | input | RW | Ceiling rate for the automatic selector |
| pre_set | input | 4 | Manual linear divider code |
| post_set | input | 4 | Manual binary divider code |
| sclk | output | 1 | Generated serial clock |
| lead_stb | output | 1 | One-cycle strobe with each edge leaving idle level |
| trail_stb | output | 1 | One-cycle strobe with each edge returning to idle level |
| cfg_err | output | 1 | Last automatic load had no valid setting |
| pre_code | output | 4 | Live linear divider code |
| post_code | output | 4 | Live binary divider code |

## Verification
The hardest case to reach is a setting that arrives while the clock is mid-phase. A load during run must stay hidden until the last trail edge, and the old half-period must persist until then. The bench starts a transfer, waits for a lead strobe, loads different manual codes, and then measures the following strobe spacing and reads the live codes before and after the stop. The selector's overflow edge is also reached directly. A ceiling of 1 with sources just above 2^18 and 2^19 lands on post = 15 and on the first failing value.

// File: rtl/spi_clk_pkg.sv
package spi_clk_pkg;
   localparam int CODE_W   = 4;
   localparam int MAX_POST = (1 << CODE_W) - 1;
   localparam int QW       = MAX_POST;

   typedef struct packed {
      logic [CODE_W-1:0] pre;
      logic [CODE_W-1:0] post;
   } div_code_t;
endpackage

// File: rtl/spi_rate_sel.sv
module spi_rate_sel
   import spi_clk_pkg::*;
#(
   parameter int RW = 24
) (
   input  logic [RW-1:0] src_i,
   input  logic [RW-1:0] max_i,
   output div_code_t     code_o,
   output logic          err_o
);
   if (RW <= CODE_W) begin : g_bad_rw
      $error("spi_rate_sel: RW must exceed CODE_W");
   end

   logic [RW-1:0] quo;
   int            idx;
   int            sh;

   always_comb begin
      quo    = '0;
      idx    = 0;
      sh     = 0;
      code_o = '0;
      err_o  = 1'b0;
      if (max_i == '0) begin
         err_o = 1'b1;
      end else if (src_i > max_i) begin
         quo = (src_i - RW'(1)) / max_i;
         for (int i = 0; i < RW; i++) begin
            if (quo[i]) idx = i + 1;
         end
         if (idx <= CODE_W) begin
            code_o.pre = quo[CODE_W-1:0];
         end else begin
            sh = idx - CODE_W;
            if (sh > MAX_POST) begin
               err_o = 1'b1;
            end else begin
               code_o.post = CODE_W'(sh);
               code_o.pre  = CODE_W'(quo >> sh);
            end
         end
      end
   end
endmodule

// File: rtl/spi_clk_cfg.sv
module spi_clk_cfg
   import spi_clk_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      load_i,
   input  logic      auto_i,
   input  div_code_t man_i,
   input  div_code_t sel_i,
   input  logic      sel_err_i,
   input  logic      busy_i,
   output div_code_t act_o,
   output logic      err_o
);
   div_code_t pend;
   logic      pend_vld;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend     <= '0;
         pend_vld <= 1'b0;
         act_o    <= '0;
         err_o    <= 1'b0;
      end else begin
         if (!busy_i && pend_vld) begin
            act_o    <= pend;
            pend_vld <= 1'b0;
         end
         if (load_i) begin
            if (auto_i && sel_err_i) begin
               err_o <= 1'b1;
            end else begin
               pend     <= auto_i ? sel_i : man_i;
               pend_vld <= 1'b1;
               err_o    <= 1'b0;
            end
         end
      end
   end

   // live codes frozen while the generator is busy
   p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
      busy_i |=> $stable(act_o));

   // rejected automatic load flags and keeps the staged setting
   p_err_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (load_i && auto_i && sel_err_i) |=> (err_o && $stable(pend)));
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
   import spi_clk_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      cpol_i,
   input  logic      run_i,
   input  div_code_t code_i,
   output logic      sclk_o,
   output logic      lead_o,
   output logic      trail_o,
   output logic      busy_o
);
   logic              pol_q;
   logic [CODE_W-1:0] pc;
   logic [QW-1:0]     qc;
   logic [QW-1:0]     qlim;
   logic              pre_wrap;
   logic              tick;

   assign qlim     = QW'((64'd1 << code_i.post) - 64'd1);
   assign pre_wrap = (pc == code_i.pre);
   assign tick     = pre_wrap && (qc == qlim);
   assign busy_o   = run_i || (sclk_o != pol_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         pol_q   <= cpol_i;
         sclk_o  <= cpol_i;
         pc      <= '0;
         qc      <= '0;
         lead_o  <= 1'b0;
         trail_o <= 1'b0;
      end else begin
         lead_o  <= 1'b0;
         trail_o <= 1'b0;
         if (!busy_o) begin
            pol_q  <= cpol_i;
            sclk_o <= cpol_i;
            pc     <= '0;
            qc     <= '0;
         end else if (tick) begin
            pc     <= '0;
            qc     <= '0;
            sclk_o <= ~sclk_o;
            if (sclk_o == pol_q) lead_o  <= 1'b1;
            else                 trail_o <= 1'b1;
         end else if (pre_wrap) begin
            pc <= '0;
            qc <= qc + 1'b1;
         end else begin
            pc <= pc + 1'b1;
         end
      end
   end

   p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
      !(lead_o && trail_o));

   p_lead_level_r4: assert property (@(posedge clk) disable iff (rst)
      lead_o |-> (sclk_o != pol_q));

   p_trail_level_r4: assert property (@(posedge clk) disable iff (rst)
      trail_o |-> (sclk_o == pol_q));

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
      pc <= code_i.pre);
endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
   import spi_clk_pkg::*;
#(
   parameter int RW      = 24,
   parameter bit AUTO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpol,
   input  logic              run,
   input  logic              cfg_load,
   input  logic              cfg_auto,
   input  logic [RW-1:0]     src_rate,
   input  logic [RW-1:0]     max_rate,
   input  logic [CODE_W-1:0] pre_set,
   input  logic [CODE_W-1:0] post_set,
   output logic              sclk,
   output logic              lead_stb,
   output logic              trail_stb,
   output logic              cfg_err,
   output logic [CODE_W-1:0] pre_code,
   output logic [CODE_W-1:0] post_code
);
   div_code_t man_code;
   div_code_t sel_code;
   div_code_t act_code;
   logic      sel_err;
   logic      use_auto;
   logic      busy;

   assign man_code = '{pre: pre_set, post: post_set};

   if (AUTO_EN) begin : g_sel
      spi_rate_sel #(.RW(RW)) u_sel (
         .src_i  (src_rate),
         .max_i  (max_rate),
         .code_o (sel_code),
         .err_o  (sel_err)
      );
      assign use_auto = cfg_auto;
   end else begin : g_nosel
      logic unused_rates;
      assign unused_rates = ^{src_rate, max_rate, cfg_auto};
      assign sel_code     = '0;
      assign sel_err      = 1'b0;
      assign use_auto     = 1'b0;
   end

   spi_clk_cfg u_cfg (
      .clk       (clk),
      .rst       (rst),
      .load_i    (cfg_load),
      .auto_i    (use_auto),
      .man_i     (man_code),
      .sel_i     (sel_code),
      .sel_err_i (sel_err),
      .busy_i    (busy),
      .act_o     (act_code),
      .err_o     (cfg_err)
   );

   spi_clk_div u_div (
      .clk     (clk),
      .rst     (rst),
      .cpol_i  (cpol),
      .run_i   (run),
      .code_i  (act_code),
      .sclk_o  (sclk),
      .lead_o  (lead_stb),
      .trail_o (trail_stb),
      .busy_o  (busy)
   );

   assign pre_code  = act_code.pre;
   assign post_code = act_code.post;
endmodule

// File: tb/spi_clk_gen_bench.sv
module spi_clk_gen_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpol = 1'b0, run = 1'b0, cfg_load = 1'b0, cfg_auto = 1'b0;
   logic [23:0] src_rate = '0, max_rate = '0;
   logic [3:0]  pre_set = '0, post_set = '0;
   logic        sclk, lead_stb, trail_stb, cfg_err;
   logic [3:0]  pre_code, post_code;

   int  nchk = 0, nfail = 0;
   bit  done = 1'b0;
   int  exp_pre = 0, exp_post = 0;

   always #4 clk = ~clk;

   spi_clk_gen #(.RW(24)) u_spi_clk_gen (
      .clk(clk), .rst(rst), .cpol(cpol), .run(run), .cfg_load(cfg_load),
      .cfg_auto(cfg_auto), .src_rate(src_rate), .max_rate(max_rate),
      .pre_set(pre_set), .post_set(post_set), .sclk(sclk),
      .lead_stb(lead_stb), .trail_stb(trail_stb), .cfg_err(cfg_err),
      .pre_code(pre_code), .post_code(post_code)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void ref_sel(input int unsigned src, input int unsigned mx,
                                   output int pre, output int post, output bit err);
      int unsigned p;
      int n;
      pre = 0; post = 0; err = 1'b0;
      if (mx == 0) err = 1'b1;
      else if (src > mx) begin
         p = (src - 1) / mx;
         n = 0;
         while ((p >> n) != 0) n++;
         if (n <= 4) pre = int'(p);
         else begin
            post = n - 4;
            if (post >= 16) begin err = 1'b1; post = 0; end
            else pre = int'(p >> post);
         end
      end
   endfunction

   task automatic pulse_load();
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic load_man(input int pre, input int post);
      cfg_auto = 1'b0;
      pre_set  = 4'(pre);
      post_set = 4'(post);
      pulse_load();
      exp_pre = pre; exp_post = post;
   endtask

   task automatic load_auto(input int unsigned src, input int unsigned mx, input string req);
      int p, q;
      bit e;
      ref_sel(src, mx, p, q, e);
      cfg_auto = 1'b1;
      src_rate = 24'(src);
      max_rate = 24'(mx);
      pulse_load();
      if (!e) begin exp_pre = p; exp_post = q; end
      chk({req, " err"}, int'(cfg_err), int'(e));
      chk({req, " pre"}, int'(pre_code), exp_pre);
      chk({req, " post"}, int'(post_code), exp_post);
   endtask

   task automatic wait_stb(input bit want_lead, input int lim, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!(want_lead ? lead_stb : trail_stb) && n < lim);
   endtask

   task automatic measure(input int h);
      int n, leads;
      run = 1'b1;
      wait_stb(1'b1, 4 * h + 10, n);
      chk("R4 lead seen", int'(lead_stb), 1);
      chk("R4 sclk off idle at lead", int'(sclk), int'(!cpol));
      wait_stb(1'b0, 4 * h + 10, n);
      chk("R3 lead->trail", n, h);
      chk("R4 sclk idle at trail", int'(sclk), int'(cpol));
      wait_stb(1'b1, 4 * h + 10, n);
      chk("R3 trail->lead", n, h);
      run = 1'b0;
      wait_stb(1'b0, 4 * h + 10, n);
      chk("R11 final trail", n, h);
      leads = 0;
      for (int i = 0; i < 2 * h + 4; i++) begin
         @(negedge clk);
         if (lead_stb) leads++;
      end
      chk("R11 no new lead", leads, 0);
      chk("R2 idle level", int'(sclk), int'(cpol));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int p, q, n;
      repeat (5) @(negedge clk);
      chk("R1 sclk", int'(sclk), 0);
      chk("R1 lead", int'(lead_stb), 0);
      chk("R1 trail", int'(trail_stb), 0);
      chk("R1 pre", int'(pre_code), 0);
      chk("R1 post", int'(post_code), 0);
      chk("R1 err", int'(cfg_err), 0);
      rst = 1'b0;
      @(negedge clk);

      load_man(2, 1);
      chk("R9 pre", int'(pre_code), 2);
      chk("R9 post", int'(post_code), 1);
      measure(6);
      measure(6);

      cpol = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R2 cpol high idle", int'(sclk), 1);
      measure(6);
      load_man(0, 0);
      measure(1);
      cpol = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R2 cpol low idle", int'(sclk), 0);

      load_auto(1000, 2000, "R5 below");
      load_auto(777, 777, "R5 equal");
      load_auto(100, 10, "R6 small");
      load_auto(17, 1, "R6 sixteen");
      load_auto(1000, 10, "R7 shift");
      load_auto(32'h40001, 1, "R7 post15");
      load_auto(32'hFFFFFF, 1, "R8 overflow");
      load_auto(32'h80001, 1, "R8 post16");
      load_auto(500, 0, "R8 zero max");
      load_auto(300, 7, "R8 clear");
      for (int i = 0; i < 40; i++) begin
         int unsigned s, m;
         s = $urandom() & 32'hFFFFFF;
         m = 1 + ($urandom() % (1 << (1 + ($urandom() % 23))));
         load_auto(s, m, "R7 random");
      end

      for (int i = 0; i < 8; i++) begin
         p = int'($urandom() % 16);
         q = int'($urandom() % 3);
         load_man(p, q);
         chk("R9 random pre", int'(pre_code), p);
         measure((p + 1) * (1 << q));
      end

      load_man(1, 1);
      run = 1'b1;
      wait_stb(1'b1, 40, n);
      cfg_auto = 1'b0; pre_set = 4'd3; post_set = 4'd0;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      @(negedge clk);
      chk("R10 pre held", int'(pre_code), 1);
      chk("R10 post held", int'(post_code), 1);
      wait_stb(1'b0, 40, n);
      wait_stb(1'b1, 40, n);
      chk("R10 old period kept", n, 4);
      run = 1'b0;
      wait_stb(1'b0, 40, n);
      chk("R11 trail after stop", n, 4);
      @(negedge clk); @(negedge clk);
      chk("R10 pre applied", int'(pre_code), 3);
      chk("R10 post applied", int'(post_code), 0);
      measure(4);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial void'($urandom(32'd1234));
endmodule